// File: doc/BRIEF.md
# Per-Port Statistics Snapshot Unit

This block keeps a bank of free-running event counters. There are `NUM_CNT` counters for each of `NUM_PORTS` ports. Every counter steps on its own single-cycle event strobe. Software never reads a live counter. It works through a 16-bit command register in two phases. A capture command freezes one port's complete counter set into a snapshot buffer in a single cycle. Read commands then fetch snapshot entries by index into a pair of 16-bit result registers. One register holds the upper half of the entry and the other holds the lower half.

Bit 15 of the command register reads as a busy flag, and software polls it after each command. A 64-bit statistic is kept in two adjacent entries and is fetched with two reads. The controller is a four-state machine:

- `S_IDLE`: accepts a command.
- `S_CAPTURE`: copies the selected port into the snapshot. Returns to `S_IDLE`.
- `S_FETCH`: registers the indexed snapshot entry. Moves to `S_LOAD`.
- `S_LOAD`: writes the result registers. Returns to `S_IDLE`.

Transitions:

- `S_IDLE -> S_CAPTURE` on a capture command.
- `S_IDLE -> S_FETCH` on a read command.
- `S_CAPTURE -> S_IDLE`, `S_FETCH -> S_LOAD` and `S_LOAD -> S_IDLE` are unconditional.

Any other write leaves the machine in `S_IDLE`.

Top module: `stats_snapshot_unit`

## Requirements
- R1: Counter `c` of port `p` is driven by strobe bit `evt_inc[p*NUM_CNT+c]`. The counter increases by exactly one at every clock edge where that bit is high. Counters whose strobes are high in the same cycle each step independently.
- R2: Each counter is `CNT_W` bits wide and wraps modulo 2^CNT_W. An entry narrower than 32 bits is zero-extended to 32 bits in the result.
- R3: A capture command has bits 15:10 = 6'b110111, i.e. 0xDC00 | port, with the port number in bits 9:0. It copies all counters of that port into the snapshot in one cycle. A strobe sampled on that capture edge counts only in the live counter. The snapshot then stays frozen until the next capture, even while the live counters keep running.
- R4: A read command has bits 15:10 = 6'b110011, i.e. 0xCC00 | index, with the index in bits 9:0. It places snapshot entry `index` in the result registers: bits 31:16 in `res_hi` and bits 15:0 in `res_lo`. The results hold until the next read completes.
- R5: `cmd_rdata[15]` is the busy flag. It is 1 from the cycle after a command is accepted until the operation ends. A capture is busy for 1 cycle and a read for 2 cycles, which is far inside a 10-poll budget.
- R6: A capture of a port ≥ `NUM_PORTS` fills the snapshot with zeros. A read of an index ≥ `NUM_CNT` returns zero in both result registers.
- R7: Two kinds of write are ignored: a write made while busy, and a write whose bits 15:10 match neither opcode. `cmd_rdata[14:0]` shows bits 14:0 of the last accepted command.
- R8: Adjacent indices k and k+1 are read independently. A 64-bit statistic therefore comes back as its low word (index k) and its high word (index k+1).
- R9: Reset clears all live counters, all snapshot entries, the result registers and the command readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inc | input | NUM_PORTS*NUM_CNT | Event strobes, bit p*NUM_CNT+c for counter c of port p |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| cmd_rdata | output | 16 | Busy flag in bit 15; bits 14:0 of the last accepted command |
| res_hi | output | 16 | Result bits 31:16 |
| res_lo | output | 16 | Result bits 15:0 |

## Verification
The hardest case to reach from the ports is a strobe that lands on the very edge where the capture copies the live counters. The stimulus handles this in a fixed order. It writes the capture command, and on the next cycle (while the machine sits in `S_CAPTURE`) it raises one strobe for exactly one cycle. A follow-up read then shows the old value in the snapshot, and a second capture shows the new one. Results wider than 16 bits need a counter above 65535. One counter is therefore driven for 70,000 consecutive cycles, and a second instance with 8-bit counters sees the same stimulus, so it checks wrap on every read.

// File: rtl/stats_snap_pkg.sv
package stats_snap_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_CAPTURE,
        S_FETCH,
        S_LOAD
    } snap_state_t;

    localparam int CMD_W  = 16;
    localparam int OPC_W  = 6;
    localparam int ARG_W  = 10;
    localparam int RES_W  = 32;
    localparam int HALF_W = 16;

    localparam logic [OPC_W-1:0] OPC_CAPTURE = 6'b110111;
    localparam logic [OPC_W-1:0] OPC_READ    = 6'b110011;
endpackage

// File: rtl/stats_cnt_bank.sv
module stats_cnt_bank #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_PORTS*NUM_CNT-1:0]                  inc,
    output logic [NUM_PORTS-1:0][NUM_CNT-1:0][CNT_W-1:0]  live
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            localparam int BIT = p * NUM_CNT + c;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live[p][c] <= '0;
                end else if (inc[BIT]) begin
                    live[p][c] <= live[p][c] + CNT_W'(1);
                end
            end

            // R1: a strobe adds exactly one, wrapping per R2
            assert_inc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
                inc[BIT] |=> live[p][c] == $past(live[p][c]) + CNT_W'(1));
            // R1: without a strobe the counter holds
            assert_inc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                !inc[BIT] |=> $stable(live[p][c]));
        end
    end
endmodule

// File: rtl/stats_snap_buf.sv
module stats_snap_buf
    import stats_snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_PORTS-1:0][NUM_CNT-1:0][CNT_W-1:0]  live,
    input  logic                                          cap_en,
    input  logic [ARG_W-1:0]                              cap_port,
    input  logic                                          fetch_en,
    input  logic [ARG_W-1:0]                              fetch_idx,
    output logic [RES_W-1:0]                              fetch_word
);
    localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int ISEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic [NUM_CNT-1:0][CNT_W-1:0] snap;
    logic                          port_ok;
    logic                          idx_ok;
    logic [PSEL_W-1:0]             psel;
    logic [ISEL_W-1:0]             isel;

    always_comb begin
        port_ok = (cap_port < ARG_W'(NUM_PORTS));
        idx_ok  = (fetch_idx < ARG_W'(NUM_CNT));
        psel    = cap_port[PSEL_W-1:0];
        isel    = fetch_idx[ISEL_W-1:0];
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap[c] <= '0;
            end else if (cap_en) begin
                snap[c] <= port_ok ? live[psel][c] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_word <= '0;
        end else if (fetch_en) begin
            fetch_word <= idx_ok ? RES_W'(snap[isel]) : '0;
        end
    end

    // R3: snapshot is frozen between captures
    assert_snap_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(snap));
    // R6: capture of a nonexistent port leaves zeros
    assert_bad_port_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !port_ok) |=> (snap == '0));
    // R6: read of a nonexistent index yields zero
    assert_bad_idx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !idx_ok) |=> (fetch_word == '0));
endmodule

// File: rtl/stats_cmd_fsm.sv
module stats_cmd_fsm
    import stats_snap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic             busy,
    output logic             cap_en,
    output logic             fetch_en,
    output logic             load_en,
    output logic [ARG_W-1:0] arg,
    output logic [CMD_W-2:0] cmd_echo
);
    snap_state_t      state_q;
    snap_state_t      state_d;
    logic [OPC_W-1:0] opc;
    logic             accept;
    logic [ARG_W-1:0] arg_q;
    logic [CMD_W-2:0] echo_q;

    always_comb begin
        opc     = cmd_wdata[CMD_W-1 -: OPC_W];
        accept  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_wr && opc == OPC_CAPTURE) begin
                    state_d = S_CAPTURE;
                    accept  = 1'b1;
                end else if (cmd_wr && opc == OPC_READ) begin
                    state_d = S_FETCH;
                    accept  = 1'b1;
                end
            end
            S_CAPTURE: state_d = S_IDLE;
            S_FETCH:   state_d = S_LOAD;
            S_LOAD:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            echo_q <= '0;
        end else if (accept) begin
            arg_q  <= cmd_wdata[ARG_W-1:0];
            echo_q <= cmd_wdata[CMD_W-2:0];
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        cap_en   = (state_q == S_CAPTURE);
        fetch_en = (state_q == S_FETCH);
        load_en  = (state_q == S_LOAD);
        arg      = arg_q;
        cmd_echo = echo_q;
    end

    // R5: capture occupies one busy cycle
    assert_capture_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAPTURE) |=> (state_q == S_IDLE));
    // R5: read occupies two busy cycles
    assert_fetch_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |=> (state_q == S_LOAD));
    assert_load_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) |=> (state_q == S_IDLE));
    // R7: writes during busy do not disturb the latched command
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(arg_q) && $stable(echo_q)));
endmodule

// File: rtl/stats_snapshot_unit.sv
module stats_snapshot_unit
    import stats_snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PORTS*NUM_CNT-1:0] evt_inc,
    input  logic                         cmd_wr,
    input  logic [15:0]                  cmd_wdata,
    output logic [15:0]                  cmd_rdata,
    output logic [15:0]                  res_hi,
    output logic [15:0]                  res_lo
);
    logic [NUM_PORTS-1:0][NUM_CNT-1:0][CNT_W-1:0] live;
    logic                                         busy;
    logic                                         cap_en;
    logic                                         fetch_en;
    logic                                         load_en;
    logic [ARG_W-1:0]                             arg;
    logic [CMD_W-2:0]                             cmd_echo;
    logic [RES_W-1:0]                             fetch_word;
    logic [RES_W-1:0]                             res_q;

    stats_cnt_bank #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_CNT   (NUM_CNT),
        .CNT_W     (CNT_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt_inc),
        .live  (live)
    );

    stats_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .cap_en    (cap_en),
        .fetch_en  (fetch_en),
        .load_en   (load_en),
        .arg       (arg),
        .cmd_echo  (cmd_echo)
    );

    stats_snap_buf #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_CNT   (NUM_CNT),
        .CNT_W     (CNT_W)
    ) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live),
        .cap_en     (cap_en),
        .cap_port   (arg),
        .fetch_en   (fetch_en),
        .fetch_idx  (arg),
        .fetch_word (fetch_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (load_en) begin
            res_q <= fetch_word;
        end
    end

    always_comb begin
        res_hi    = res_q[RES_W-1 -: HALF_W];
        res_lo    = res_q[HALF_W-1:0];
        cmd_rdata = {busy, cmd_echo};
    end

    // R4: result registers change only at the end of a read
    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(res_hi) && $stable(res_lo)));
endmodule

// File: tb/stats_snapshot_unit_tb.sv
`timescale 1ns/1ps
module stats_snapshot_unit_tb_top;
    localparam int NP = 4;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*NC-1:0] evt = '0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_wdata = '0;
    logic [15:0]   rd_i, hi_i, lo_i;
    logic [15:0]   rd_w, hi_w, lo_w;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    int unsigned exp_live [NP][NC];
    int unsigned exp_snap [NC];

    always #2.5 clk = ~clk;

    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNT(NC), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(rd_i), .res_hi(hi_i), .res_lo(lo_i));

    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNT(NC), .CNT_W(8)) dut_w (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(rd_w), .res_hi(hi_w), .res_lo(lo_w));

    typedef struct packed {
        logic [1:0]  port;
        logic [2:0]  idx;
        logic [7:0]  n;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{2'd0, 3'd0, 8'd3, 32'd3},
        '{2'd0, 3'd0, 8'd2, 32'd5},
        '{2'd1, 3'd7, 8'd4, 32'd4},
        '{2'd3, 3'd2, 8'd1, 32'd1},
        '{2'd2, 3'd5, 8'd6, 32'd6},
        '{2'd1, 3'd7, 8'd0, 32'd4},
        '{2'd0, 3'd1, 8'd7, 32'd7},
        '{2'd3, 3'd2, 8'd2, 32'd3}
    };

    task automatic summary_and_end();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            summary_and_end();
        end
    end

    task automatic check32(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_res(string tag, logic [31:0] expv);
        check32(tag, {hi_i, lo_i}, expv);
        check32({tag, " R2 wrap"}, {hi_w, lo_w}, expv & 32'h0000_00FF);
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++) exp_live[p][c] = 0;
        for (int c = 0; c < NC; c++) exp_snap[c] = 0;
    endtask

    task automatic bump(int p, int c, int n);
        if (n > 0) begin
            @(negedge clk);
            evt[p*NC+c] = 1'b1;
            repeat (n) @(negedge clk);
            evt[p*NC+c] = 1'b0;
            exp_live[p][c] += n;
        end
    endtask

    task automatic issue(logic [15:0] cmd, output int bc);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_wr = 1'b0;
        bc = 0;
        while (rd_i[15] && bc < 20) begin
            bc++;
            @(negedge clk);
        end
    endtask

    task automatic capture(int p, output int bc);
        issue(16'hDC00 | 16'(p), bc);
        for (int c = 0; c < NC; c++) exp_snap[c] = (p < NP) ? exp_live[p][c] : 0;
    endtask

    task automatic read_chk(int idx, string tag, output int bc);
        issue(16'hCC00 | 16'(idx), bc);
        check_res(tag, (idx < NC) ? exp_snap[idx] : 32'd0);
    endtask

    initial begin
        int bc;
        logic [31:0] prev;
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset state
        check32("R9 reset results", {hi_i, lo_i}, 32'd0);
        check32("R9 reset cmd_rdata", {16'd0, rd_i}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: table walk
        foreach (VT[k]) begin
            bump(int'(VT[k].port), int'(VT[k].idx), int'(VT[k].n));
            capture(int'(VT[k].port), bc);
            issue(16'hCC00 | 16'(VT[k].idx), bc);
            check_res($sformatf("R1 R3 R4 table %0d", k), VT[k].expv);
        end

        // R5: busy lengths
        capture(0, bc);
        check32("R5 capture busy cycles", bc, 1);
        read_chk(0, "R4 read port0 idx0", bc);
        check32("R5 read busy cycles", bc, 2);
        check32("R5 within poll budget", {31'd0, bc <= 10}, 1);

        // R1: simultaneous strobes on a whole port
        @(negedge clk);
        evt[NC+:NC] = '1;
        repeat (5) @(negedge clk);
        evt = '0;
        for (int c = 0; c < NC; c++) exp_live[1][c] += 5;
        capture(1, bc);
        for (int c = 0; c < NC; c++) read_chk(c, $sformatf("R1 parallel idx%0d", c), bc);

        // R4 R2: value wider than 16 bits, wraps in 8-bit instance
        bump(2, 3, 70000);
        capture(2, bc);
        read_chk(3, "R4 split 70000", bc);
        check32("R4 res_hi", {16'd0, hi_i}, 32'h0000_0001);
        check32("R4 res_lo", {16'd0, lo_i}, 32'h0000_1170);

        // R3: strobe on the capture edge counts only live
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = 16'hDC00;
        @(negedge clk);
        cmd_wr = 1'b0;
        evt[4] = 1'b1;
        for (int c = 0; c < NC; c++) exp_snap[c] = exp_live[0][c];
        @(negedge clk);
        evt = '0;
        exp_live[0][4] += 1;
        read_chk(4, "R3 capture-edge strobe excluded", bc);
        capture(0, bc);
        read_chk(4, "R3 capture-edge strobe in live", bc);

        // R3: frozen while live counts
        capture(3, bc);
        bump(3, 2, 9);
        read_chk(2, "R3 snapshot frozen", bc);

        // R8: adjacent indices
        bump(2, 6, 11);
        bump(2, 7, 22);
        capture(2, bc);
        read_chk(6, "R8 low word idx6", bc);
        read_chk(7, "R8 high word idx7", bc);

        // R6: out of range
        read_chk(8, "R6 index 8", bc);
        read_chk(1023, "R6 index 1023", bc);
        capture(4, bc);
        read_chk(0, "R6 port 4 snapshot", bc);

        // R7: command while busy ignored
        capture(0, bc);
        read_chk(1, "R7 setup", bc);
        prev = {hi_i, lo_i};
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = 16'hDC01;
        @(negedge clk);
        cmd_wdata = 16'hCC02;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (3) @(negedge clk);
        check32("R7 echo keeps first command", {17'd0, rd_i[14:0]}, 32'h0000_5C01);
        check32("R7 results untouched", {hi_i, lo_i}, prev);

        // R7: unknown opcode ignored
        issue(16'h1234, bc);
        check32("R7 unknown opcode no busy", bc, 0);
        check32("R7 unknown opcode echo", {17'd0, rd_i[14:0]}, 32'h0000_5C01);
        check32("R7 unknown opcode results", {hi_i, lo_i}, prev);

        // R9: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check32("R9 results after reset", {hi_i, lo_i}, 32'd0);
        capture(0, bc);
        read_chk(0, "R9 live cleared", bc);

        summary_and_end();
    end
endmodule